// File: doc/BRIEF.md
# Request-Acknowledge Bus Synchronizer

This block carries a multi-bit word from a source clock domain into a destination clock domain that runs on an unrelated clock. It does not pass each data bit through its own synchronizer. The source stores the word in a holding register and raises a single request line. That request is synchronized into the destination, where its arrival loads the held bus into an output register in one step. An acknowledge level then travels back to the source. The source lowers its request only after the acknowledge arrives, and it offers a new word only after the acknowledge has dropped again. This four-phase level exchange keeps the held bus steady for the whole time the destination may sample it, whatever the ratio between the two clocks.

The source side is a valid/ready input. A word is taken on a source clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high only while no transfer is in flight. This back-pressure is the only flow control: a source that holds `s_valid` while `s_ready` is low is simply not served, and the data on the bus at that time is discarded. The destination side has no back-pressure. Each received word appears on `d_data` together with a single-cycle `d_valid` strobe. The block is meant for control words and settings that change rarely. One full round trip across both clock domains is needed per word.

Top module: `req_ack_bus_sync`

## Requirements
- R1: After reset of both domains, `s_ready` is 1, `d_valid` is 0 and `d_data` is all zeros.
- R2: A word is accepted on a source clock edge where `s_valid` and `s_ready` are both 1, and `s_ready` is 0 in the following source cycle.
- R3: Asserting `s_valid` while `s_ready` is 0 has no effect: that data is never delivered, and the delivered stream holds only accepted words.
- R4: The delivered word is bit-identical to the accepted word. The held copy does not change until the next acceptance.
- R5: Each accepted word produces exactly one `d_valid` pulse, one destination cycle wide, with the word on `d_data` in that same cycle. Words are delivered in acceptance order.
- R6: `d_data` keeps its value in every destination cycle in which `d_valid` is 0.
- R7: `d_valid` is raised no later than SYNC_STAGES+2 rising destination edges after the accepting source edge.
- R8: The request falls only once the synchronized acknowledge is high. `s_ready` returns to 1 only after the word has been delivered and the synchronized acknowledge has fallen.
- R9: R4, R5 and R8 hold for a destination clock that is faster than, close to, or much slower than the source clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s_clk | input | 1 | Source domain clock |
| s_rst | input | 1 | Source domain synchronous reset, active high |
| s_data | input | DATA_W | Word offered by the source |
| s_valid | input | 1 | Source offers `s_data` |
| s_ready | output | 1 | Block can take a word (idle) |
| d_clk | input | 1 | Destination domain clock |
| d_rst | input | 1 | Destination domain synchronous reset, active high |
| d_data | output | DATA_W | Last received word |
| d_valid | output | 1 | One-cycle strobe marking a new word on `d_data` |

## Verification
`s_ready` falls in the source cycle right after an accepting edge, so the bench checks it at the next falling source edge. `d_valid` is due within SYNC_STAGES+2 rising destination edges of acceptance: one edge may miss the new request, SYNC_STAGES edges pass it through the synchronizer, and one more loads the output. The bench timestamps each acceptance and checks the elapsed time when the strobe is seen at a falling destination edge, allowing the extra half period. The reference queue is compared on every destination clock. Each time `s_ready` comes back, the bench checks that nothing accepted is still waiting to be delivered. The run uses four destination periods: below, near and well above the source period.

// File: rtl/rab_pkg.sv
package rab_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE    = 2'd0,
    SRC_WAIT_HI = 2'd1,
    SRC_WAIT_LO = 2'd2
  } src_state_t;
endpackage

// File: rtl/rab_level_sync.sv
module rab_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rab_src_ctrl.sv
module rab_src_ctrl
  import rab_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              ack_sync,
  output logic              req,
  output logic [DATA_W-1:0] hold_data
);
  src_state_t state_q, state_d;
  logic       req_q;
  logic [DATA_W-1:0] hold_q;
  logic take;

  assign in_ready = (state_q == SRC_IDLE);
  assign take     = in_valid && in_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRC_IDLE:    if (in_valid)  state_d = SRC_WAIT_HI;
      SRC_WAIT_HI: if (ack_sync)  state_d = SRC_WAIT_LO;
      SRC_WAIT_LO: if (!ack_sync) state_d = SRC_IDLE;
      default:                    state_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SRC_IDLE;
      req_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        hold_q <= in_data;
        req_q  <= 1'b1;
      end else if (state_q == SRC_WAIT_HI && ack_sync) begin
        req_q  <= 1'b0;
      end
    end
  end

  assign req       = req_q;
  assign hold_data = hold_q;

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(hold_data));
  a_r8_req_falls_on_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(ack_sync));
  a_r8_ready_after_ack_low: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> !$past(ack_sync) && !$past(req));
endmodule

// File: rtl/rab_dst_capture.sv
module rab_dst_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_sync,
  input  logic [DATA_W-1:0] bus_data,
  output logic              ack,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);
  logic              ack_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic              load;

  assign load = req_sync && !ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      ack_q   <= req_sync;
      valid_q <= load;
      if (load) data_q <= bus_data;
    end
  end

  assign ack       = ack_q;
  assign out_data  = data_q;
  assign out_valid = valid_q;

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  a_r6_data_held: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
  a_r5_pulse_with_ack: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ack);
endmodule

// File: rtl/req_ack_bus_sync.sv
module req_ack_bus_sync #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              s_clk,
  input  logic              s_rst,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              d_clk,
  input  logic              d_rst,
  output logic [DATA_W-1:0] d_data,
  output logic              d_valid
);
  logic              req_src;
  logic              req_dst;
  logic              ack_dst;
  logic              ack_src;
  logic [DATA_W-1:0] held_bus;

  rab_src_ctrl #(.DATA_W(DATA_W)) u_src (
    .clk       (s_clk),
    .rst       (s_rst),
    .in_data   (s_data),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .ack_sync  (ack_src),
    .req       (req_src),
    .hold_data (held_bus)
  );

  rab_level_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk  (d_clk),
    .rst  (d_rst),
    .din  (req_src),
    .dout (req_dst)
  );

  rab_dst_capture #(.DATA_W(DATA_W)) u_dst (
    .clk       (d_clk),
    .rst       (d_rst),
    .req_sync  (req_dst),
    .bus_data  (held_bus),
    .ack       (ack_dst),
    .out_data  (d_data),
    .out_valid (d_valid)
  );

  rab_level_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (s_clk),
    .rst  (s_rst),
    .din  (ack_dst),
    .dout (ack_src)
  );
endmodule

// File: tb/tb_req_ack_bus_sync.sv
`timescale 1ns/1ps
module tb_req_ack_bus_sync;
  localparam int DATA_W = 8;
  localparam int SYNC   = 2;
  localparam real S_HALF = 2.0;

  logic s_clk = 0, d_clk = 0, s_rst = 1, d_rst = 1;
  logic [DATA_W-1:0] s_data = '0;
  logic s_valid = 0;
  logic s_ready, d_valid;
  logic [DATA_W-1:0] d_data;

  real d_half = 1.7;
  int  compared = 0, mismatched = 0;
  logic [DATA_W-1:0] exp_q[$];
  real acc_t[$];
  logic [DATA_W-1:0] last_d = '0;
  logic prev_dv = 0;
  bit   done = 0;

  always #(S_HALF) s_clk = ~s_clk;
  always #(d_half) d_clk = ~d_clk;

  req_ack_bus_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) dut (
    .s_clk(s_clk), .s_rst(s_rst), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .d_clk(d_clk), .d_rst(d_rst), .d_data(d_data), .d_valid(d_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // destination reference compare, every destination clock
  always @(negedge d_clk) begin
    if (!d_rst) begin
      if (d_valid) begin
        chk(prev_dv == 0, "R5 pulse width", 1, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R3/R5 unexpected word", d_data, 0);
        end else begin
          logic [DATA_W-1:0] e;
          real t0, lim;
          e = exp_q.pop_front();
          t0 = acc_t.pop_front();
          chk(d_data == e, "R4/R9 delivered word", d_data, e);
          lim = (SYNC + 2.5) * 2.0 * d_half + 0.01;
          chk(($realtime - t0) <= lim, "R7 latency",
              int'(($realtime - t0) * 10), int'(lim * 10));
        end
        last_d = d_data;
      end else begin
        chk(d_data == last_d, "R6 data held", d_data, last_d);
      end
      prev_dv = d_valid;
    end
  end

  // one source cycle: sample at falling edge, then drive new inputs
  task automatic src_cycle(input bit v, input logic [DATA_W-1:0] dat);
    @(negedge s_clk);
    s_valid = v;
    s_data  = dat;
    @(posedge s_clk);
    if (v && s_ready) begin
      exp_q.push_back(dat);
      acc_t.push_back($realtime);
      @(negedge s_clk);
      chk(s_ready == 0, "R2 ready drops", s_ready, 0);
      s_valid = 0;
    end
  endtask

  task automatic send_word(input logic [DATA_W-1:0] dat, input bit noisy);
    bit sent = 0;
    while (!sent) begin
      @(negedge s_clk);
      if (s_ready) begin
        s_valid = 1; s_data = dat;
        @(posedge s_clk);
        exp_q.push_back(dat);
        acc_t.push_back($realtime);
        sent = 1;
        @(negedge s_clk);
        chk(s_ready == 0, "R2 ready drops", s_ready, 0);
        s_valid = 0;
      end
    end
    // wait for ready again; R3 noise while busy, R8 delivery before ready
    while (!s_ready) begin
      @(negedge s_clk);
      if (noisy) begin s_valid = 1; s_data = ~dat; end
      if (s_ready) begin
        s_valid = 0;
        chk(exp_q.size() == 0, "R8 ready before delivery", exp_q.size(), 0);
      end
    end
    s_valid = 0;
  endtask

  task automatic drain();
    repeat (400) @(negedge s_clk);
    chk(exp_q.size() == 0, "R5 word lost", exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge s_clk);
    @(negedge d_clk); d_rst = 0;
    @(negedge s_clk); s_rst = 0;
    @(negedge s_clk);
    chk(s_ready == 1, "R1 ready after reset", s_ready, 1);
    chk(d_valid == 0, "R1 valid after reset", d_valid, 0);
    chk(d_data == 0, "R1 data after reset", d_data, 0);
    for (int ph = 0; ph < 4; ph++) begin
      d_half = (ph == 0) ? 1.7 : (ph == 1) ? 2.3 : (ph == 2) ? 13.1 : 0.9;
      repeat (3) @(negedge s_clk);
      send_word('0, 0);
      send_word('1, 1);
      send_word(8'hA5, 1);
      for (int i = 0; i < 12; i++) send_word(DATA_W'($urandom), (i % 2) == 1);
      src_cycle(0, 8'h00);
      drain();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge s_clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule